// File: doc/BRIEF.md
# Indirect Command/Status Bus Bridge

This block gives a 64-bit control bus a way to reach a 32-bit internal peripheral bus through four 64-bit registers. Software places store data in a data register. It then writes a command word that carries a read/write flag, a byte count and a 32-bit target address, and that write starts exactly one peripheral-bus transaction. When the transaction finishes, the status register holds a completion flag, together with the returned data for a read. Reading the status register clears it.

On the peripheral side the bridge raises a request with a valid/ready handshake. It then waits for a single response strobe, which carries read data and an error bit. Data travels big-endian: the most significant byte of the 32-bit word is the first byte on the bus. Only one transaction can be outstanding at a time. Command words that arrive while one is in flight are dropped, and so are command words with a byte count above eight.

Top module: `ind_cmd_bridge`

## Requirements
- R1: Control-bus address bits [4:3] pick the register: 0 command, 1 reset, 2 status, 3 data. The other address bits play no part in the decode.
- R2: A write to the command register starts one request. Bit 48 set means a read and clear means a write. Bits [59:56] are the byte count and bits [31:0] the peripheral address. The request fields stay stable while valid is high and ready is low.
- R3: A command whose byte count is greater than 8 issues no request and leaves the status register unchanged. A count of exactly 8 is accepted.
- R4: A read that completes without error sets status to bit 11 plus the 32-bit response data in bits [57:26]. The first byte on the bus (response bits [31:24]) lands in status bits [57:50].
- R5: A read that completes with the error bit set sets status to bit 11 with bits [57:26] all ones.
- R6: A write that completes sets status to exactly 64'h800, whatever the error bit says. Its write data is the data register value, with the most significant byte on bus bits [31:24].
- R7: A write to the data register keeps bits [63:32] of the written word. A read returns that value in bits [63:32] with zeros below.
- R8: A status read returns the current value and clears the register. If a completion lands in the same cycle, the read returns the old value and the new result is kept.
- R9: Reads of the command and reset registers return zero. Writes to the reset and status registers change nothing.
- R10: A command write while a transaction is outstanding is ignored. A data-register write during that time does not alter the in-flight write data. A response strobe with nothing outstanding is ignored.
- R11: While the synchronous active-high reset is asserted, the status and data registers clear to zero, no request is raised and no read data is flagged valid.
- R12: Read data appears on csr_rdata with csr_rvalid high in the cycle after the read is presented, and csr_rvalid is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_valid | input | 1 | Control-bus access strobe |
| csr_write | input | 1 | 1 = write access, 0 = read access |
| csr_addr | input | CSR_AW | Control-bus byte address |
| csr_wdata | input | 64 | Control-bus write data |
| csr_rvalid | output | 1 | Read data valid |
| csr_rdata | output | 64 | Read data |
| pb_req_valid | output | 1 | Peripheral request valid |
| pb_req_ready | input | 1 | Peripheral request accepted |
| pb_req_write | output | 1 | 1 = store, 0 = load |
| pb_req_addr | output | PB_AW | Peripheral address |
| pb_req_size | output | 4 | Byte count |
| pb_req_wdata | output | PB_DW | Store data, first byte in the top lane |
| pb_rsp_valid | input | 1 | Response strobe |
| pb_rsp_err | input | 1 | Response error |
| pb_rsp_rdata | input | PB_DW | Load data, first byte in the top lane |

## Verification
The bench aims at the status register's edges. A completion that coincides with a status read is tested: a design that lets the clear win loses the result. A failed read is tested: a design that forwards the bus data instead of ones reports garbage. A write whose response carries the error bit is tested: a design that marks that error leaves stray status bits. The byte-count boundary is probed at 8 and 9 and with the widest field value. A design that compares with the wrong bound either drops a legal 8-byte access or launches one that must be rejected. Stray command writes, data-register writes and response strobes are injected while a transaction is outstanding or the bridge is idle. A design that re-launches, re-captures its store data or posts a phantom completion then shows a wrong request field or a wrong status word.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_RST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PB_IDLE = 2'd0,
    PB_REQ  = 2'd1,
    PB_WAIT = 2'd2
  } pb_state_e;

  localparam int unsigned SEL_LSB       = 3;
  localparam int unsigned CMD_RD_BIT    = 48;
  localparam int unsigned CMD_SZ_LSB    = 56;
  localparam int unsigned SZ_W          = 4;
  localparam int unsigned MAX_BYTES     = 8;
  localparam int unsigned STAT_DONE_BIT = 11;
  localparam int unsigned STAT_DATA_LSB = 26;
  localparam int unsigned WORD_W        = 64;
endpackage

// File: rtl/ibr_csr_decode.sv
module ibr_csr_decode
  import ibr_pkg::*;
#(
  parameter int CSR_AW = 16,
  parameter int PB_AW  = 32
) (
  input  logic [CSR_AW-1:0] addr_i,
  input  logic [WORD_W-1:0] word_i,
  output reg_sel_e          sel_o,
  output logic              cmd_rd_o,
  output logic [SZ_W-1:0]   cmd_size_o,
  output logic [PB_AW-1:0]  cmd_addr_o,
  output logic              cmd_legal_o
);
  logic unused_bits;

  assign sel_o       = reg_sel_e'(addr_i[SEL_LSB +: 2]);
  assign cmd_rd_o    = word_i[CMD_RD_BIT];
  assign cmd_size_o  = word_i[CMD_SZ_LSB +: SZ_W];
  assign cmd_addr_o  = word_i[PB_AW-1:0];
  assign cmd_legal_o = (int'(cmd_size_o) <= MAX_BYTES);
  assign unused_bits = ^{addr_i, word_i};
endmodule

// File: rtl/ibr_pb_master.sv
module ibr_pb_master
  import ibr_pkg::*;
#(
  parameter int PB_AW = 32,
  parameter int PB_DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic [PB_AW-1:0] addr_i,
  input  logic [PB_DW-1:0] wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             done_rd_o,
  output logic             done_err_o,
  output logic [PB_DW-1:0] done_data_o,
  output logic             pb_req_valid,
  input  logic             pb_req_ready,
  output logic             pb_req_write,
  output logic [PB_AW-1:0] pb_req_addr,
  output logic [SZ_W-1:0]  pb_req_size,
  output logic [PB_DW-1:0] pb_req_wdata,
  input  logic             pb_rsp_valid,
  input  logic             pb_rsp_err,
  input  logic [PB_DW-1:0] pb_rsp_rdata
);
  pb_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PB_IDLE;
      pb_req_valid <= 1'b0;
      pb_req_write <= 1'b0;
      pb_req_addr  <= '0;
      pb_req_size  <= '0;
      pb_req_wdata <= '0;
    end else begin
      case (state_q)
        PB_IDLE: if (start_i) begin
          state_q      <= PB_REQ;
          pb_req_valid <= 1'b1;
          pb_req_write <= ~rd_i;
          pb_req_addr  <= addr_i;
          pb_req_size  <= size_i;
          pb_req_wdata <= wdata_i;
        end
        PB_REQ: if (pb_req_ready) begin
          state_q      <= PB_WAIT;
          pb_req_valid <= 1'b0;
        end
        PB_WAIT: if (pb_rsp_valid) state_q <= PB_IDLE;
        default: state_q <= PB_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != PB_IDLE);
  assign done_o      = (state_q == PB_WAIT) && pb_rsp_valid;
  assign done_rd_o   = ~pb_req_write;
  assign done_err_o  = pb_rsp_err;
  assign done_data_o = pb_rsp_rdata;
endmodule

// File: rtl/ind_cmd_bridge.sv
module ind_cmd_bridge
  import ibr_pkg::*;
#(
  parameter int CSR_AW = 16,
  parameter int PB_AW  = 32,
  parameter int PB_DW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_valid,
  input  logic              csr_write,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [63:0]       csr_wdata,
  output logic              csr_rvalid,
  output logic [63:0]       csr_rdata,
  output logic              pb_req_valid,
  input  logic              pb_req_ready,
  output logic              pb_req_write,
  output logic [PB_AW-1:0]  pb_req_addr,
  output logic [3:0]        pb_req_size,
  output logic [PB_DW-1:0]  pb_req_wdata,
  input  logic              pb_rsp_valid,
  input  logic              pb_rsp_err,
  input  logic [PB_DW-1:0]  pb_rsp_rdata
);
  localparam int DATA_HI = WORD_W - PB_DW;

  reg_sel_e          sel;
  logic              cmd_rd, cmd_legal;
  logic [SZ_W-1:0]   cmd_size;
  logic [PB_AW-1:0]  cmd_addr;
  logic              csr_rd, csr_wr, start;
  logic              pb_busy, cpl_done, cpl_rd, cpl_err;
  logic [PB_DW-1:0]  cpl_data;
  logic [PB_DW-1:0]  data_q;
  logic [63:0]       status_q;
  logic [63:0]       cpl_word;

  ibr_csr_decode #(.CSR_AW(CSR_AW), .PB_AW(PB_AW)) u_dec (
    .addr_i(csr_addr), .word_i(csr_wdata), .sel_o(sel),
    .cmd_rd_o(cmd_rd), .cmd_size_o(cmd_size), .cmd_addr_o(cmd_addr),
    .cmd_legal_o(cmd_legal)
  );

  assign csr_rd = csr_valid & ~csr_write;
  assign csr_wr = csr_valid & csr_write;
  assign start  = csr_wr && (sel == SEL_CMD) && cmd_legal;

  ibr_pb_master #(.PB_AW(PB_AW), .PB_DW(PB_DW)) u_pbm (
    .clk(clk), .rst(rst), .start_i(start), .rd_i(cmd_rd),
    .size_i(cmd_size), .addr_i(cmd_addr), .wdata_i(data_q),
    .busy_o(pb_busy), .done_o(cpl_done), .done_rd_o(cpl_rd),
    .done_err_o(cpl_err), .done_data_o(cpl_data),
    .pb_req_valid(pb_req_valid), .pb_req_ready(pb_req_ready),
    .pb_req_write(pb_req_write), .pb_req_addr(pb_req_addr),
    .pb_req_size(pb_req_size), .pb_req_wdata(pb_req_wdata),
    .pb_rsp_valid(pb_rsp_valid), .pb_rsp_err(pb_rsp_err),
    .pb_rsp_rdata(pb_rsp_rdata)
  );

  always_comb begin
    cpl_word = '0;
    cpl_word[STAT_DONE_BIT] = 1'b1;
    if (cpl_rd) cpl_word[STAT_DATA_LSB +: PB_DW] = cpl_err ? '1 : cpl_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q     <= '0;
      status_q   <= '0;
      csr_rvalid <= 1'b0;
      csr_rdata  <= '0;
    end else begin
      csr_rvalid <= csr_rd;
      if (csr_rd) begin
        case (sel)
          SEL_STAT: csr_rdata <= status_q;
          SEL_DATA: csr_rdata <= {data_q, {DATA_HI{1'b0}}};
          default:  csr_rdata <= '0;
        endcase
      end
      if (csr_wr && sel == SEL_DATA) data_q <= csr_wdata[WORD_W-1 -: PB_DW];
      if (cpl_done) status_q <= cpl_word;
      else if (csr_rd && sel == SEL_STAT) status_q <= '0;
    end
  end
endmodule

// File: rtl/ind_cmd_bridge_chk.sv
module ind_cmd_bridge_chk #(
  parameter int PB_AW = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             csr_valid,
  input logic             csr_write,
  input logic [1:0]       csr_sel,
  input logic [3:0]       wsize,
  input logic             csr_rvalid,
  input logic             pb_req_valid,
  input logic             pb_req_ready,
  input logic [PB_AW-1:0] pb_req_addr,
  input logic [31:0]      pb_req_wdata,
  input logic             pb_busy,
  input logic             cpl_done,
  input logic             cpl_rd,
  input logic [63:0]      status_q
);
  logic cmd_wr, stat_rd, any_rd;
  assign cmd_wr  = csr_valid && csr_write && csr_sel == 2'd0;
  assign stat_rd = csr_valid && !csr_write && csr_sel == 2'd2;
  assign any_rd  = csr_valid && !csr_write;

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    pb_req_valid && !pb_req_ready |=> pb_req_valid && $stable(pb_req_addr) && $stable(pb_req_wdata));

  assert_big_size_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && wsize > 4'd8 && !pb_busy |=> !pb_req_valid);

  assert_read_status_R4: assert property (@(posedge clk) disable iff (rst)
    cpl_done && cpl_rd |=> status_q[11] && status_q[63:58] == 6'd0 && status_q[25:0] == 26'h800);

  assert_write_status_R6: assert property (@(posedge clk) disable iff (rst)
    cpl_done && !cpl_rd |=> status_q == 64'h800);

  assert_status_clear_R8: assert property (@(posedge clk) disable iff (rst)
    stat_rd && !cpl_done |=> status_q == 64'd0);

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && pb_busy |=> $stable(pb_req_addr));

  assert_rvalid_follows_R12: assert property (@(posedge clk) disable iff (rst)
    any_rd |=> csr_rvalid);

  assert_rvalid_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !any_rd |=> !csr_rvalid);
endmodule

bind ind_cmd_bridge ind_cmd_bridge_chk #(.PB_AW(PB_AW)) u_chk (
  .clk(clk), .rst(rst), .csr_valid(csr_valid), .csr_write(csr_write),
  .csr_sel(csr_addr[4:3]), .wsize(csr_wdata[59:56]), .csr_rvalid(csr_rvalid),
  .pb_req_valid(pb_req_valid), .pb_req_ready(pb_req_ready),
  .pb_req_addr(pb_req_addr), .pb_req_wdata(pb_req_wdata[31:0]),
  .pb_busy(pb_busy), .cpl_done(cpl_done), .cpl_rd(cpl_rd), .status_q(status_q)
);

// File: tb/ind_cmd_bridge_tb.sv
`timescale 1ns/100ps
module ind_cmd_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_valid = 1'b0, csr_write = 1'b0;
  logic [15:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic        csr_rvalid;
  logic [63:0] csr_rdata;
  logic        pb_req_valid, pb_req_write;
  logic        pb_req_ready = 1'b0;
  logic [31:0] pb_req_addr, pb_req_wdata;
  logic [3:0]  pb_req_size;
  logic        pb_rsp_valid = 1'b0, pb_rsp_err = 1'b0;
  logic [31:0] pb_rsp_rdata = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ind_cmd_bridge u_dut (
    .clk(clk), .rst(rst), .csr_valid(csr_valid), .csr_write(csr_write),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rvalid(csr_rvalid),
    .csr_rdata(csr_rdata), .pb_req_valid(pb_req_valid), .pb_req_ready(pb_req_ready),
    .pb_req_write(pb_req_write), .pb_req_addr(pb_req_addr), .pb_req_size(pb_req_size),
    .pb_req_wdata(pb_req_wdata), .pb_rsp_valid(pb_rsp_valid), .pb_rsp_err(pb_rsp_err),
    .pb_rsp_rdata(pb_rsp_rdata)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, driven only by the bench's inputs.
  logic        m_busy, m_reqv, m_rd, m_rvalid;
  logic [31:0] m_addr, m_wdata, m_data;
  logic [3:0]  m_size;
  logic [63:0] m_status, m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_reqv = 0; m_rd = 0; m_rvalid = 0;
      m_addr = 0; m_wdata = 0; m_data = 0; m_size = 0;
      m_status = 0; m_rdata = 0;
    end else begin
      automatic logic        ob = m_busy, orq = m_reqv;
      automatic logic [63:0] ost = m_status;
      automatic logic [31:0] od = m_data;
      automatic int          sel = csr_addr[4:3];
      automatic bit          rd = csr_valid && !csr_write;
      automatic bit          wr = csr_valid && csr_write;
      m_rvalid = rd;
      if (rd) m_rdata = (sel == 2) ? ost : (sel == 3) ? {od, 32'h0} : 64'h0;
      if (wr && sel == 3) m_data = csr_wdata[63:32];
      if (rd && sel == 2) m_status = 0;
      if (ob && !orq && pb_rsp_valid) begin
        m_busy = 0;
        m_status = m_rd ? (64'h800 | (64'(pb_rsp_err ? 32'hFFFF_FFFF : pb_rsp_rdata) << 26))
                        : 64'h800;
      end
      if (orq && pb_req_ready) m_reqv = 0;
      if (wr && sel == 0 && csr_wdata[59:56] <= 4'd8 && !ob) begin
        m_busy = 1; m_reqv = 1; m_rd = csr_wdata[48];
        m_addr = csr_wdata[31:0]; m_size = csr_wdata[59:56]; m_wdata = od;
      end
    end
  end

  // Compare the model with the ports on every clock, away from the edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2 req_valid", 64'(pb_req_valid), 64'(m_reqv));
      if (m_reqv) begin
        chk("R2 req_write", 64'(pb_req_write), 64'(!m_rd));
        chk("R2 req_addr", 64'(pb_req_addr), 64'(m_addr));
        chk("R2 req_size", 64'(pb_req_size), 64'(m_size));
        chk("R6 req_wdata", 64'(pb_req_wdata), 64'(m_wdata));
      end
      chk("R12 rvalid", 64'(csr_rvalid), 64'(m_rvalid));
      if (m_rvalid) chk("R1 rdata", csr_rdata, m_rdata);
    end
  end

  task automatic step();
    @(posedge clk); #0.5;
  endtask

  function automatic logic [63:0] cmd(bit rd, logic [3:0] sz, logic [31:0] a);
    return {4'h0, sz, 7'h0, rd, 16'h0, a};
  endfunction

  task automatic wr(int sel, logic [63:0] d);
    csr_valid = 1; csr_write = 1; csr_addr = 16'(sel << 3); csr_wdata = d;
    step();
    csr_valid = 0; csr_write = 0;
  endtask

  task automatic rd(int sel, output logic [63:0] v);
    csr_valid = 1; csr_write = 0; csr_addr = 16'(sel << 3);
    step();
    csr_valid = 0;
    v = csr_rdata;
  endtask

  task automatic serve(int hold, int gap, logic [31:0] d, bit e);
    repeat (hold) step();
    pb_req_ready = 1; step(); pb_req_ready = 0;
    repeat (gap) step();
    pb_rsp_valid = 1; pb_rsp_rdata = d; pb_rsp_err = e;
    step();
    pb_rsp_valid = 0; pb_rsp_err = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [63:0] v;
    repeat (3) step();
    chk("R11 req_valid in reset", 64'(pb_req_valid), 64'h0);
    chk("R11 rvalid in reset", 64'(csr_rvalid), 64'h0);
    rst = 0;
    rd(2, v); chk("R11 status after reset", v, 64'h0);
    rd(3, v); chk("R11 data after reset", v, 64'h0);

    wr(3, 64'hA1B2C3D4_55667788);
    rd(3, v); chk("R7 data readback", v, 64'hA1B2C3D4_00000000);
    chk("R12 rvalid after read", 64'(csr_rvalid), 64'h1);
    step(); chk("R12 rvalid drops", 64'(csr_rvalid), 64'h0);
    rd(0, v); chk("R9 cmd reads zero", v, 64'h0);
    rd(1, v); chk("R9 reset reads zero", v, 64'h0);
    wr(1, '1); wr(2, '1);
    rd(2, v); chk("R9 status write ignored", v, 64'h0);
    rd(3, v); chk("R9 reset write ignored", v, 64'hA1B2C3D4_00000000);

    // store, response carries error
    wr(0, cmd(0, 4'd4, 32'h1234_5678));
    chk("R2 store launched", 64'(pb_req_valid), 64'h1);
    chk("R6 store data", 64'(pb_req_wdata), 64'hA1B2C3D4);
    serve(2, 1, 32'h0, 1);
    rd(2, v); chk("R6 store status", v, 64'h800);
    rd(2, v); chk("R8 status cleared", v, 64'h0);

    // load ok
    wr(0, cmd(1, 4'd4, 32'hC001_2038));
    chk("R2 load direction", 64'(pb_req_write), 64'h0);
    serve(0, 2, 32'hDEAD_BEEF, 0);
    rd(2, v); chk("R4 load status", v, 64'h800 | (64'hDEADBEEF << 26));
    chk("R4 first byte position", 64'(v[57:50]), 64'hDE);

    // load error, leave status unread
    wr(0, cmd(1, 4'd2, 32'h0000_0060));
    serve(1, 0, 32'h1234_5678, 1);
    wr(0, cmd(1, 4'd9, 32'h0000_0100));
    step(); chk("R3 size 9 no request", 64'(pb_req_valid), 64'h0);
    wr(0, cmd(0, 4'd15, 32'h0000_0200));
    step(); chk("R3 size 15 no request", 64'(pb_req_valid), 64'h0);
    rd(2, v); chk("R5 error status kept by R3", v, 64'h800 | (64'hFFFFFFFF << 26));

    // size 8 boundary and busy behaviour
    wr(0, cmd(0, 4'd8, 32'hE001_0000));
    chk("R3 size 8 accepted", 64'(pb_req_valid), 64'h1);
    chk("R3 size 8 field", 64'(pb_req_size), 64'h8);
    wr(3, 64'h11112222_00000000);
    wr(0, cmd(1, 4'd1, 32'hF000_0000));
    chk("R10 addr unchanged while busy", 64'(pb_req_addr), 64'hE001_0000);
    chk("R10 wdata unchanged while busy", 64'(pb_req_wdata), 64'hA1B2C3D4);
    serve(1, 1, 32'h5555_5555, 0);
    repeat (3) step();
    chk("R10 no second request", 64'(pb_req_valid), 64'h0);

    // completion coincides with a status read (status holds 0x800)
    wr(0, cmd(1, 4'd1, 32'hD001_0060));
    pb_req_ready = 1; step(); pb_req_ready = 0;
    pb_rsp_valid = 1; pb_rsp_rdata = 32'h8C00_0000;
    csr_valid = 1; csr_write = 0; csr_addr = 16'(2 << 3);
    step();
    pb_rsp_valid = 0; csr_valid = 0;
    chk("R8 same-cycle read returns old", csr_rdata, 64'h800);
    rd(2, v); chk("R8 new result kept", v, 64'h800 | (64'h8C000000 << 26));

    // idle response strobe
    pb_rsp_valid = 1; pb_rsp_rdata = 32'h0BAD_0BAD; step(); pb_rsp_valid = 0;
    rd(2, v); chk("R10 idle response ignored", v, 64'h0);

    // address decode with stray bits
    csr_valid = 1; csr_write = 0; csr_addr = 16'h0080 | 16'(3 << 3) | 16'h5;
    step(); csr_valid = 0;
    chk("R1 decode uses bits 4:3", csr_rdata, 64'h11112222_00000000);

    repeat (2) step();
    summary();
  end
endmodule